// File: doc/BRIEF.md
# Per-Port Audio Master Clock Selector

This block chooses, for every serial audio port, which of several candidate master clocks drives it. The candidates arrive as single-cycle clock-enable pulses in the system clock domain: three direct external audio clock inputs (A, B, C), an auxiliary input I, and the outputs of two baud-rate generators, one tuned to the 44.1 kHz family and one to the 48 kHz family. Each port turns its selected candidate into its own clock-enable pulse stream. It can also stop that stream entirely.

Software programs the selection through 32-bit select registers. Each register holds four 8-bit per-port fields, and each port decodes its field into a one-hot choice among the six candidates, or into "stopped". A new choice is not applied at once while the port is running. The port keeps its current source until that source's next pulse has been emitted, so a port never gets a truncated clock period. Port 8 has no selector of its own. It always reproduces port 7's clock, and writes aimed at its field are discarded.

Top module: `audclk_mux`

## Requirements
- R1: While reset is asserted, and after it is released until a field is written, every `port_ce` bit stays 0 whatever `src_ce` does.
- R2: Port p's 8-bit field is written by `wr_en` with `wr_addr` = p/4, taking `wr_data` bits [(p%4)*8+7 : (p%4)*8], and only when `wr_be[p%4]` is 1. Fields in other byte lanes keep their value.
- R3: Field code 0x01 selects `src_ce[1]` (input A), 0x02 selects `src_ce[2]` (input B) and 0x03 selects `src_ce[3]` (input C).
- R4: Field code 0x10 selects `src_ce[4]` (44.1k-family generator) and 0x20 selects `src_ce[5]` (48k-family generator).
- R5: Field code 0x00 stops the port, so `src_ce[0]` (input I) has no effect at the default setting ZERO_SELECTS_I = 0. With ZERO_SELECTS_I = 1, code 0x00 selects `src_ce[0]` instead.
- R6: Every code not listed in R3 to R5 stops the port, and its output stays 0.
- R7: A pulse on the selected source in one cycle gives exactly one `port_ce` pulse in the following cycle. There is no combinational path from `src_ce` to `port_ce`.
- R8: A running port changes its selection only in a cycle where its current source pulses, and that pulse is still delivered. A stopped port applies a new selection in the cycle after the field write.
- R9: Writes to port 8's field (register 2, bits 7:0) are ignored, and `port_ce[8]` always equals `port_ce[7]`.
- R10: Writes with `wr_addr` = 3 change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Select register number |
| wr_data | input | 32 | Write data, four 8-bit port fields |
| wr_be | input | 4 | Byte-lane write enables, one per field |
| src_ce | input | 6 | Candidate clock-enable pulses: [0] I, [1] A, [2] B, [3] C, [4] 44.1k generator, [5] 48k generator |
| port_ce | output | 10 | Per-port clock-enable pulses |

## Verification
A vector table programs ports in all three registers with each defined code, the zero code and several undefined codes. It then pulses one candidate at a time, which separates a correct source match from a neighbouring source or a stopped port. Directed sequences pulse a new source before the old one to show that the switch waits for the old source's pulse. They also stop a running port, which must emit a final pulse and then go quiet, and restart a stopped port, which must react without waiting. Further sequences write single byte lanes and register 3 to expose write-decode faults, and program ports 7 and 8 differently to show that port 8 tracks port 7.

// File: rtl/audclk_mux_pkg.sv
`timescale 1ns/1ps
package audclk_mux_pkg;

  localparam int FIELD_W = 8;
  localparam int NUM_SRC = 6;

  // candidate index inside src_ce
  localparam int SRC_I   = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 2;
  localparam int SRC_C   = 3;
  localparam int SRC_G44 = 4;
  localparam int SRC_G48 = 5;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [FIELD_W-1:0] sel_code_t;

  localparam sel_code_t CODE_ZERO = 8'h00;
  localparam sel_code_t CODE_A    = 8'h01;
  localparam sel_code_t CODE_B    = 8'h02;
  localparam sel_code_t CODE_C    = 8'h03;
  localparam sel_code_t CODE_G44  = 8'h10;
  localparam sel_code_t CODE_G48  = 8'h20;

  // field code -> one-hot candidate choice, all zero meaning stopped
  function automatic src_vec_t decode_sel(input sel_code_t code, input bit zero_is_i);
    src_vec_t v;
    v = '0;
    case (code)
      CODE_A:    v[SRC_A]   = 1'b1;
      CODE_B:    v[SRC_B]   = 1'b1;
      CODE_C:    v[SRC_C]   = 1'b1;
      CODE_G44:  v[SRC_G44] = 1'b1;
      CODE_G48:  v[SRC_G48] = 1'b1;
      CODE_ZERO: v[SRC_I]   = zero_is_i;
      default:   v          = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/clksel_rst_sync.sv
`timescale 1ns/1ps
module clksel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/clksel_regfile.sv
`timescale 1ns/1ps
module clksel_regfile
  import audclk_mux_pkg::*;
#(
  parameter int NUM_PORTS      = 10,
  parameter int FIELDS_PER_REG = 4,
  parameter int ADDR_W         = 2,
  parameter int FOLLOW_PORT    = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [FIELDS_PER_REG*FIELD_W-1:0]   wr_data,
  input  logic [FIELDS_PER_REG-1:0]           wr_be,
  output logic [NUM_PORTS-1:0][FIELD_W-1:0]   fld
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fld
    localparam int                LANE  = p % FIELDS_PER_REG;
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(p / FIELDS_PER_REG);

    if (p == FOLLOW_PORT) begin : g_none
      // no storage: this port mirrors its neighbour
      assign fld[p] = '0;
    end else begin : g_store
      sel_code_t fld_q;
      sel_code_t fld_d;
      logic      fld_we;

      always_comb begin
        fld_we = wr_en && (wr_addr == REG_A) && wr_be[LANE];
        fld_d  = fld_we ? wr_data[LANE*FIELD_W +: FIELD_W] : fld_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= CODE_ZERO;
        else        fld_q <= fld_d;
      end

      assign fld[p] = fld_q;
    end
  end

endmodule

// File: rtl/clksel_port.sv
`timescale 1ns/1ps
module clksel_port
  import audclk_mux_pkg::*;
#(
  parameter bit ZERO_SELECTS_I = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sel_code_t code,
  input  src_vec_t  src_ce,
  output src_vec_t  cur_sel,
  output logic      ce
);

  src_vec_t req_sel;
  src_vec_t cur_q;
  src_vec_t cur_d;
  logic     ce_q;
  logic     ce_d;
  logic     hit;
  logic     boundary;

  always_comb begin
    req_sel  = decode_sel(code, ZERO_SELECTS_I);
    hit      = |(cur_q & src_ce);
    // switch only when stopped or when the running period just ended
    boundary = (cur_q == '0) || hit;
    cur_d    = boundary ? req_sel : cur_q;
    ce_d     = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      cur_q <= cur_d;
      ce_q  <= ce_d;
    end
  end

  assign cur_sel = cur_q;
  assign ce      = ce_q;

endmodule

// File: rtl/audclk_mux.sv
`timescale 1ns/1ps
module audclk_mux
  import audclk_mux_pkg::*;
#(
  parameter int NUM_PORTS      = 10,
  parameter int FIELDS_PER_REG = 4,
  parameter int ADDR_W         = 2,
  parameter int FOLLOW_PORT    = 8,
  parameter int LEAD_PORT      = 7,
  parameter bit ZERO_SELECTS_I = 1'b0
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [ADDR_W-1:0]                         wr_addr,
  input  logic [FIELDS_PER_REG*FIELD_W-1:0]         wr_data,
  input  logic [FIELDS_PER_REG-1:0]                 wr_be,
  input  logic [NUM_SRC-1:0]                        src_ce,
  output logic [NUM_PORTS-1:0]                      port_ce
);

  logic                              rst_sync_n;
  logic [NUM_PORTS-1:0][FIELD_W-1:0] fld;
  logic [NUM_PORTS-1:0][NUM_SRC-1:0] cur_sel_all;
  logic [NUM_PORTS-1:0]              own_ce;

  clksel_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  clksel_regfile #(
    .NUM_PORTS     (NUM_PORTS),
    .FIELDS_PER_REG(FIELDS_PER_REG),
    .ADDR_W        (ADDR_W),
    .FOLLOW_PORT   (FOLLOW_PORT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_be  (wr_be),
    .fld    (fld)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == FOLLOW_PORT) begin : g_follow
      assign own_ce[p]      = 1'b0;
      assign cur_sel_all[p] = '0;
      assign port_ce[p]     = own_ce[LEAD_PORT];
    end else begin : g_mux
      clksel_port #(.ZERO_SELECTS_I(ZERO_SELECTS_I)) u_sel (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .code   (fld[p]),
        .src_ce (src_ce),
        .cur_sel(cur_sel_all[p]),
        .ce     (own_ce[p])
      );
      assign port_ce[p] = own_ce[p];
    end
  end

endmodule

// File: rtl/audclk_mux_chk.sv
`timescale 1ns/1ps
module audclk_mux_chk
  import audclk_mux_pkg::*;
#(
  parameter int NUM_PORTS      = 10,
  parameter int FIELDS_PER_REG = 4,
  parameter int ADDR_W         = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [ADDR_W-1:0]                 wr_addr,
  input logic [NUM_SRC-1:0]                src_ce,
  input logic [NUM_PORTS-1:0]              port_ce,
  input logic [NUM_PORTS-1:0][NUM_SRC-1:0] cur_sel,
  input logic [NUM_PORTS-1:0][FIELD_W-1:0] fld
);

  localparam int NUM_REGS = (NUM_PORTS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

  AST_NO_PULSE_WITHOUT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ce == '0) |=> (port_ce == '0)) else $error("no-source pulse"); // R7

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(fld)) else $error("unmapped write"); // R10

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cur_sel[p])) else $error("selection not one-hot"); // R3

    AST_HOLD_UNTIL_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_sel[p] != '0) && ((cur_sel[p] & src_ce) == '0)) |=> $stable(cur_sel[p]))
      else $error("switch inside a period"); // R8
  end

endmodule

bind audclk_mux audclk_mux_chk #(
  .NUM_PORTS     (NUM_PORTS),
  .FIELDS_PER_REG(FIELDS_PER_REG),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .src_ce (src_ce),
  .port_ce(port_ce),
  .cur_sel(cur_sel_all),
  .fld    (fld)
);

// File: tb/audclk_mux_test.sv
`timescale 1ns/1ps
module audclk_mux_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic [5:0]  src_ce;
  logic [9:0]  port_ce;

  int checks = 0;
  int fails  = 0;

  audclk_mux uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_be  (wr_be),
    .src_ce (src_ce),
    .port_ce(port_ce)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {port[3:0], code[7:0], source index[2:0], expected[0]}
  localparam int NVEC = 16;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd0, 8'h01, 3'd1, 1'b1},  // R3 A on port 0
    {4'd0, 8'h01, 3'd2, 1'b0},  // R3 B must not pass
    {4'd1, 8'h02, 3'd2, 1'b1},  // R3
    {4'd1, 8'h02, 3'd1, 1'b0},  // R3
    {4'd2, 8'h03, 3'd3, 1'b1},  // R3
    {4'd3, 8'h10, 3'd4, 1'b1},  // R4
    {4'd3, 8'h10, 3'd5, 1'b0},  // R4
    {4'd4, 8'h20, 3'd5, 1'b1},  // R4 register 1
    {4'd5, 8'h20, 3'd4, 1'b0},  // R4
    {4'd6, 8'h00, 3'd0, 1'b0},  // R5 input I ignored
    {4'd6, 8'h03, 3'd3, 1'b1},  // R3
    {4'd7, 8'h04, 3'd3, 1'b0},  // R6
    {4'd9, 8'hFF, 3'd5, 1'b0},  // R6 register 2
    {4'd9, 8'h11, 3'd4, 1'b0},  // R6
    {4'd9, 8'h01, 3'd1, 1'b1},  // R3 register 2
    {4'd2, 8'h30, 3'd5, 1'b0}   // R6
  };

  function automatic string tag_of(input logic [7:0] code);
    case (code)
      8'h01, 8'h02, 8'h03: return "R3";
      8'h10, 8'h20:        return "R4";
      8'h00:               return "R5";
      default:             return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  // drive one source pulse; returns at the negedge where its result is visible
  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    src_ce = m;
    @(negedge clk);
    src_ce = '0;
  endtask

  task automatic set_port(input int p, input logic [7:0] code);
    wreg(2'(p / 4), 32'(code) << ((p % 4) * 8), 4'(1 << (p % 4)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0; src_ce = '0;

    // R1 reset state
    @(negedge clk); src_ce = 6'h3F;
    @(negedge clk);
    check("R1 in reset", 32'(port_ce), 32'h0);
    @(negedge clk); src_ce = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse(6'h3F);
    check("R1 after release", 32'(port_ce), 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      int          p;
      logic [7:0]  code;
      int          s;
      logic        exp;
      p    = int'(VEC[i][15:12]);
      code = VEC[i][11:4];
      s    = int'(VEC[i][3:1]);
      exp  = VEC[i][0];
      set_port(p, code);
      pulse(6'h3F);            // ends the running period, new choice applies
      pulse(6'(1 << s));
      check(tag_of(code), 32'(port_ce[p]), 32'(exp));
    end

    // R2 byte lanes
    wreg(2'd0, 32'h01010101, 4'hF);
    pulse(6'h3F);
    wreg(2'd0, 32'h20202020, 4'b0100);
    pulse(6'h3F);
    pulse(6'b000010);
    check("R2 lane A", 32'(port_ce[3:0]), 32'hB);
    pulse(6'b100000);
    check("R2 lane G48", 32'(port_ce[3:0]), 32'h4);

    // R10 register 3 write ignored
    wreg(2'd3, 32'h00000000, 4'hF);
    pulse(6'h3F);
    pulse(6'b000010);
    check("R10 addr3", 32'(port_ce[3:0]), 32'hB);

    // R9 port 8 follows port 7
    set_port(7, 8'h02);
    wreg(2'd2, 32'h00000001, 4'b0001);
    pulse(6'h3F);
    pulse(6'b000010);
    check("R9 port8 on A", 32'(port_ce[8:7]), 32'h0);
    pulse(6'b000100);
    check("R9 port8 on B", 32'(port_ce[8:7]), 32'h3);

    // R8 switch waits for the current source
    set_port(0, 8'h03);
    pulse(6'b001000);
    check("R8 new source early", 32'(port_ce[0]), 32'h0);
    pulse(6'b000010);
    check("R8 old source final", 32'(port_ce[0]), 32'h1);
    pulse(6'b000010);
    check("R8 old source gone", 32'(port_ce[0]), 32'h0);
    pulse(6'b001000);
    check("R8 new source live", 32'(port_ce[0]), 32'h1);
    set_port(0, 8'h00);
    pulse(6'h3F);
    check("R8 stop final pulse", 32'(port_ce[0]), 32'h1);
    pulse(6'h3F);
    check("R5 stopped", 32'(port_ce[0]), 32'h0);
    set_port(0, 8'h10);
    pulse(6'b010000);
    check("R8 restart from stop", 32'(port_ce[0]), 32'h1);

    // R7 one-cycle latency, single pulse
    @(negedge clk); src_ce = 6'b000010;
    #1;
    check("R7 no comb path", 32'(port_ce[1]), 32'h0);
    @(negedge clk);
    check("R7 pulse", 32'(port_ce[1]), 32'h1);
    src_ce = '0;
    @(negedge clk);
    check("R7 single", 32'(port_ce[1]), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule